// File: doc/BRIEF.md
# Peripheral Bus Adapter with Interrupt Masking

This block connects a host to an external parallel peripheral bus. The host uses four function codes. It can reset the bus, store a control word (or read status), start a transfer, and load a two-channel interrupt enable register. The control word names a device and a mode. Its read bit decides whether a transfer moves data in or out.

Every transfer has two phases. The adapter first places the stored control word on the bus for one control cycle. On a write, it then drives the registered write data in the next cycle. On a read, it keeps the control word on the bus for a settling window of at least the configured time, then captures the bus data. The captured data goes back to the host with a one-cycle valid pulse.

Two active-low device requests are masked by the enables and combined into a level interrupt to the host. The interrupt carries the winning channel number, and channel 0 wins over channel 1. When the host acknowledges, the enable of the reported channel clears, and it stays clear until software writes the enable register again. Parity errors from the local side and the remote side set sticky flags, and a bus reset clears them.

Top module: `pbus_adapter`

## Requirements
- R1: After reset, all of these are low: busy, host interrupt, read-valid, bus reset, bus drive enable and both strobes. Both enables and both parity flags are clear.
- R2: A request with function code 1 and host_wr high stores host_wdata as the control word. With host_wr low, it returns the status word on host_rdata in the next cycle, with a one-cycle host_rvalid. The status word is: bit 0 = request 0 (raw, active low), bit 1 = request 1 (raw), bit 2 = local parity flag, bit 3 = remote parity flag, bit 4 = enable 0, bit 5 = enable 1, all higher bits zero.
- R3: A request with function code 2 starts a transfer. In the first cycle after it, bus_ctl_stb is high and bus_ad equals the control word.
- R4: If the control word's read bit (bit DATA_W-8) is set, bus_ad keeps the control word for SETTLE_CYC more cycles, SETTLE_CYC = ceil(CLK_MHZ*SETTLE_NS/1000). In the last of those cycles, bus_dat_stb is high and bus_din is captured. On the next cycle, host_rdata holds the captured value with host_rvalid high for one cycle.
- R5: If the read bit is clear, the cycle after the control cycle drives the host_wdata value registered at the request, with bus_dat_strobe high. The adapter then returns to idle.
- R6: host_busy is high from the cycle after an accepted transfer or reset command until it finishes. Any request made while host_busy is high is ignored.
- R7: A request with function code 0 drives bus_rst high for RST_CYC cycles and clears both parity flags.
- R8: The parity flags are sticky. A parity error that arrives in the same cycle as a clear still sets its flag.
- R9: A request with function code 3 loads the enables from host_wdata[1:0].
- R10: A channel is pending when its request is low and its enable is set. host_irq is the OR of the pending channels. host_irq_chan is 0 whenever channel 0 is pending, and 1 otherwise.
- R11: host_irq_ack while host_irq is high clears the enable of the reported channel. An enable write in the same cycle takes precedence.
- R12: bus_ad_oe is high only during the control, settle and write-data cycles. At all other times, bus_ad is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe from the host |
| host_wr | input | 1 | Write (1) or read (0) for function code 1 |
| host_fn | input | 2 | Function code: 0 bus reset, 1 control/status, 2 transfer, 3 enables |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Status or captured bus data |
| host_rvalid | output | 1 | One-cycle valid for host_rdata |
| host_busy | output | 1 | Transfer or bus reset in progress |
| host_irq | output | 1 | Level interrupt to the host |
| host_irq_chan | output | 1 | Channel number being reported |
| host_irq_ack | input | 1 | Host acknowledges the reported channel |
| bus_ad | output | DATA_W | Address/data word driven onto the bus |
| bus_ad_oe | output | 1 | Drive enable for bus_ad |
| bus_ctl_stb | output | 1 | Control-word cycle marker |
| bus_dat_stb | output | 1 | Data cycle marker (write drive or read sample) |
| bus_rst | output | 1 | Peripheral bus reset |
| bus_din | input | DATA_W | Data returned by the bus |
| bus_req_n | input | 2 | Active-low device interrupt requests |
| bus_perr_local | input | 1 | Local parity error pulse |
| bus_perr_remote | input | 1 | Remote parity error pulse |

## Verification
The bench uses DATA_W = 16, CLK_MHZ = 250 and SETTLE_NS = 32, so the read settling window is 8 cycles, and RST_CYC = 3. At these sizes, a complete read with its full hold time fits in a few cycles of simulation. Ignored requests can land both in the settling window and during bus reset. A long randomized run then covers many transfers that mix reads, writes, acknowledges and parity pulses.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CTRL   = 3'd1,
        PH_SETTLE = 3'd2,
        PH_DATA   = 3'd3,
        PH_BRST   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        FN_BRST = 2'd0,
        FN_CTRL = 2'd1,
        FN_XFER = 2'd2,
        FN_IEN  = 2'd3
    } fn_e;

    // Status layout, MSB first: bit 5 down to bit 0
    typedef struct packed {
        logic ien1;
        logic ien0;
        logic perr_remote;
        logic perr_local;
        logic req1_n;
        logic req0_n;
    } status_t;

    localparam int STATUS_W = 6;

    // Settling cycles for a given clock and hold time, rounded up, never below one
    function automatic int settle_cycles(input int mhz, input int ns);
        int c;
        c = (mhz * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Fixed priority: channel 0 wins
    function automatic logic pick_chan(input logic [1:0] pend);
        return pend[0] ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SETTLE_CYC = 250,
    parameter int RST_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_xfer,
    input  logic              start_brst,
    input  logic              rd_mode,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] wr_word,
    output logic              busy,
    output logic              drive_oe,
    output logic              ctl_stb,
    output logic              dat_stb,
    output logic              sample,
    output logic              bus_rst,
    output logic [DATA_W-1:0] drive_word
);
    localparam int CNT_MAX = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] RST_LAST    = CNT_W'(RST_CYC - 1);

    phase_e            ph_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] wq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            wq_q  <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start_brst) begin
                        ph_q  <= PH_BRST;
                        cnt_q <= RST_LAST;
                    end else if (start_xfer) begin
                        ph_q <= PH_CTRL;
                        wq_q <= wr_word;
                    end
                end
                PH_CTRL: begin
                    ph_q  <= rd_mode ? PH_SETTLE : PH_DATA;
                    cnt_q <= SETTLE_LAST;
                end
                PH_SETTLE, PH_BRST: begin
                    if (cnt_q == '0) ph_q <= PH_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                PH_DATA: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (ph_q != PH_IDLE);
        ctl_stb  = (ph_q == PH_CTRL);
        sample   = (ph_q == PH_SETTLE) && (cnt_q == '0);
        dat_stb  = (ph_q == PH_DATA) || sample;
        bus_rst  = (ph_q == PH_BRST);
        drive_oe = (ph_q == PH_CTRL) || (ph_q == PH_SETTLE) || (ph_q == PH_DATA);
        if (ph_q == PH_CTRL || ph_q == PH_SETTLE) drive_word = ctrl_word;
        else if (ph_q == PH_DATA)                 drive_word = wq_q;
        else                                      drive_word = '0;
    end

endmodule

// File: rtl/pbus_irq.sv
module pbus_irq
    import pbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req_n,
    input  logic       en_wr,
    input  logic [1:0] en_wdata,
    input  logic       ack,
    output logic [1:0] en,
    output logic       irq,
    output logic       chan
);
    logic [1:0] pend;

    always_comb begin
        pend = ~req_n & en;
        irq  = |pend;
        chan = pick_chan(pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (en_wr) begin
            en <= en_wdata;
        end else if (ack && irq) begin
            en[chan] <= 1'b0;
        end
    end

endmodule

// File: rtl/pbus_adapter.sv
module pbus_adapter
    import pbus_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CLK_MHZ   = 250,
    parameter int SETTLE_NS = 1000,
    parameter int RST_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [1:0]        host_fn,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              host_busy,
    output logic              host_irq,
    output logic              host_irq_chan,
    input  logic              host_irq_ack,
    output logic [DATA_W-1:0] bus_ad,
    output logic              bus_ad_oe,
    output logic              bus_ctl_stb,
    output logic              bus_dat_stb,
    output logic              bus_rst,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [1:0]        bus_req_n,
    input  logic              bus_perr_local,
    input  logic              bus_perr_remote
);
    localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_NS);
    localparam int RD_BIT     = DATA_W - 8;

    fn_e               fn;
    logic              accept, go_brst, go_ctrl, go_stat, go_xfer, go_ien;
    logic [DATA_W-1:0] ctrl_q;
    logic [1:0]        perr_q;
    logic [1:0]        ien_q;
    logic              sample;
    status_t           st;

    always_comb begin
        fn      = fn_e'(host_fn);
        accept  = host_req && !host_busy;
        go_brst = accept && (fn == FN_BRST);
        go_ctrl = accept && (fn == FN_CTRL) && host_wr;
        go_stat = accept && (fn == FN_CTRL) && !host_wr;
        go_xfer = accept && (fn == FN_XFER);
        go_ien  = accept && (fn == FN_IEN);
        st      = '{ien1: ien_q[1], ien0: ien_q[0],
                    perr_remote: perr_q[1], perr_local: perr_q[0],
                    req1_n: bus_req_n[1], req0_n: bus_req_n[0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            perr_q      <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            if (go_ctrl) ctrl_q <= host_wdata;
            perr_q      <= (perr_q & {2{~go_brst}}) | {bus_perr_remote, bus_perr_local};
            host_rvalid <= sample || go_stat;
            if (sample)       host_rdata <= bus_din;
            else if (go_stat) host_rdata <= {{(DATA_W-STATUS_W){1'b0}}, st};
        end
    end

    pbus_seq #(
        .DATA_W    (DATA_W),
        .SETTLE_CYC(SETTLE_CYC),
        .RST_CYC   (RST_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_xfer(go_xfer),
        .start_brst(go_brst),
        .rd_mode   (ctrl_q[RD_BIT]),
        .ctrl_word (ctrl_q),
        .wr_word   (host_wdata),
        .busy      (host_busy),
        .drive_oe  (bus_ad_oe),
        .ctl_stb   (bus_ctl_stb),
        .dat_stb   (bus_dat_stb),
        .sample    (sample),
        .bus_rst   (bus_rst),
        .drive_word(bus_ad)
    );

    pbus_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .req_n   (bus_req_n),
        .en_wr   (go_ien),
        .en_wdata(host_wdata[1:0]),
        .ack     (host_irq_ack),
        .en      (ien_q),
        .irq     (host_irq),
        .chan    (host_irq_chan)
    );

endmodule

// File: rtl/pbus_adapter_chk.sv
module pbus_adapter_chk
    import pbus_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CLK_MHZ   = 250,
    parameter int SETTLE_NS = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic [1:0]        host_fn,
    input logic              host_busy,
    input logic              host_irq,
    input logic              host_irq_chan,
    input logic              host_irq_ack,
    input logic [1:0]        bus_req_n,
    input logic              bus_ad_oe,
    input logic              bus_ctl_stb,
    input logic              bus_dat_stb,
    input logic              bus_rst,
    input logic [1:0]        ien,
    input logic [1:0]        perr,
    input logic [DATA_W-1:0] ctrl
);
    localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_NS);
    localparam int RD_BIT     = DATA_W - 8;

    int unsigned hold_cnt;

    // Cycles spent holding the control word after its strobe cycle
    always_ff @(posedge clk) begin
        if (rst)                            hold_cnt <= 0;
        else if (bus_ctl_stb)               hold_cnt <= 0;
        else if (bus_ad_oe)                 hold_cnt <= hold_cnt + 1;
    end

    p_strobes_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_ctl_stb && bus_dat_stb));

    p_ctl_single_r3: assert property (@(posedge clk) disable iff (rst)
        bus_ctl_stb |=> host_busy && !bus_ctl_stb);

    // Sample cycle is the SETTLE_CYC-th settle cycle, counter starts at 0
    p_settle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_dat_stb && ctrl[RD_BIT]) |-> (hold_cnt == SETTLE_CYC - 1));

    p_write_data_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_ctl_stb && !ctrl[RD_BIT]) |=> (bus_dat_stb && bus_ad_oe));

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (host_busy && host_req) |=> $stable(ctrl));

    p_brst_busy_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rst |-> (host_busy && !bus_ad_oe));

    p_perr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (perr[0] && !(host_req && !host_busy && host_fn == 2'd0)) |=> perr[0]);

    p_irq_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (host_irq && host_irq_chan) |-> !(ien[0] && !bus_req_n[0]));

    p_ack_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (host_irq && host_irq_ack && !(host_req && !host_busy && host_fn == 2'd3))
        |=> !ien[$past(host_irq_chan)]);

endmodule

bind pbus_adapter pbus_adapter_chk #(
    .DATA_W   (DATA_W),
    .CLK_MHZ  (CLK_MHZ),
    .SETTLE_NS(SETTLE_NS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_req     (host_req),
    .host_fn      (host_fn),
    .host_busy    (host_busy),
    .host_irq     (host_irq),
    .host_irq_chan(host_irq_chan),
    .host_irq_ack (host_irq_ack),
    .bus_req_n    (bus_req_n),
    .bus_ad_oe    (bus_ad_oe),
    .bus_ctl_stb  (bus_ctl_stb),
    .bus_dat_stb  (bus_dat_stb),
    .bus_rst      (bus_rst),
    .ien          (ien_q),
    .perr         (perr_q),
    .ctrl         (ctrl_q)
);

// File: tb/pbus_adapter_tb.sv
`timescale 1ns/1ps
module pbus_adapter_tb;
    localparam int DW   = 16;
    localparam int MHZ  = 250;
    localparam int SNS  = 32;
    localparam int SET  = 8;   // ceil(250*32/1000)
    localparam int RSTC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0, host_wr = 1'b0, host_irq_ack = 1'b0;
    logic [1:0]    host_fn = 2'd0;
    logic [DW-1:0] host_wdata = '0, bus_din = '0;
    logic [1:0]    bus_req_n = 2'b11;
    logic          bus_perr_local = 1'b0, bus_perr_remote = 1'b0;
    logic [DW-1:0] host_rdata, bus_ad;
    logic          host_rvalid, host_busy, host_irq, host_irq_chan;
    logic          bus_ad_oe, bus_ctl_stb, bus_dat_stb, bus_rst;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pbus_adapter #(.DATA_W(DW), .CLK_MHZ(MHZ), .SETTLE_NS(SNS), .RST_CYC(RSTC)) u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr), .host_fn(host_fn),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .host_busy(host_busy), .host_irq(host_irq), .host_irq_chan(host_irq_chan),
        .host_irq_ack(host_irq_ack), .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe),
        .bus_ctl_stb(bus_ctl_stb), .bus_dat_stb(bus_dat_stb), .bus_rst(bus_rst),
        .bus_din(bus_din), .bus_req_n(bus_req_n), .bus_perr_local(bus_perr_local),
        .bus_perr_remote(bus_perr_remote));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_ph, m_cnt;            // 0 idle 1 ctrl 2 settle 3 data 4 reset
    logic [DW-1:0] m_ctrl, m_wq, m_rdata;
    logic          m_rvalid;
    logic [1:0]    m_en, m_perr;
    logic          t_acc, t_ienw;
    logic [1:0]    t_pend;
    logic [DW-1:0] t_stat;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_ctrl = '0; m_wq = '0; m_rdata = '0;
            m_rvalid = 0; m_en = '0; m_perr = '0;
        end else begin
            t_acc  = host_req && (m_ph == 0);
            t_ienw = t_acc && host_fn == 2'd3;
            t_pend = ~bus_req_n & m_en;
            t_stat = DW'({m_en, m_perr, bus_req_n});
            m_rvalid = 0;
            if (t_acc && host_fn == 2'd0) m_perr = 2'b00;
            m_perr = m_perr | {bus_perr_remote, bus_perr_local};
            if (t_ienw) m_en = host_wdata[1:0];
            else if (host_irq_ack && t_pend != 0) begin
                if (t_pend[0]) m_en[0] = 1'b0; else m_en[1] = 1'b0;
            end
            case (m_ph)
                0: if (t_acc) begin
                    case (host_fn)
                        2'd0: begin m_ph = 4; m_cnt = RSTC - 1; end
                        2'd1: if (host_wr) m_ctrl = host_wdata;
                              else begin m_rdata = t_stat; m_rvalid = 1; end
                        2'd2: begin m_wq = host_wdata; m_ph = 1; end
                        default: ;
                    endcase
                end
                1: begin m_ph = m_ctrl[DW-8] ? 2 : 3; m_cnt = SET - 1; end
                2: if (m_cnt == 0) begin m_rdata = bus_din; m_rvalid = 1; m_ph = 0; end
                   else m_cnt--;
                3: m_ph = 0;
                4: if (m_cnt == 0) m_ph = 0; else m_cnt--;
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [1:0] p;
            p = ~bus_req_n & m_en;
            chk("R6 busy", host_busy, m_ph != 0);
            chk("R3 ctl_stb", bus_ctl_stb, m_ph == 1);
            chk("R5 dat_stb", bus_dat_stb, (m_ph == 3) || (m_ph == 2 && m_cnt == 0));
            chk("R12 oe", bus_ad_oe, m_ph >= 1 && m_ph <= 3);
            chk("R12 bus_ad", bus_ad, (m_ph == 1 || m_ph == 2) ? m_ctrl : (m_ph == 3) ? m_wq : '0);
            chk("R7 bus_rst", bus_rst, m_ph == 4);
            chk("R4 rvalid", host_rvalid, m_rvalid);
            chk("R2 rdata", host_rdata, m_rdata);
            chk("R10 irq", host_irq, |p);
            if (|p) chk("R10 chan", host_irq_chan, p[0] ? 1'b0 : 1'b1);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic issue(input logic [1:0] fn, input logic wr, input logic [DW-1:0] d);
        host_req = 1; host_fn = fn; host_wr = wr; host_wdata = d;
        cyc();
        host_req = 0;
    endtask

    task automatic wait_idle();
        while (host_busy) cyc();
    endtask

    initial begin
        logic [31:0] lcg;
        int n;
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 busy", host_busy, 0);
        chk("R1 irq", host_irq, 0);
        chk("R1 rvalid", host_rvalid, 0);
        chk("R1 bus_rst", bus_rst, 0);
        chk("R1 oe", bus_ad_oe, 0);
        issue(2'd1, 0, '0);
        chk("R1 status", host_rdata, 16'h0003);
        chk("R2 rvalid", host_rvalid, 1);

        // read transfer, device 0x5A, read bit set
        issue(2'd1, 1, 16'hB500);
        bus_din = 16'hBEEF;
        issue(2'd2, 0, '0);
        chk("R3 ctl_stb", bus_ctl_stb, 1);
        chk("R3 ctrl word", bus_ad, 16'hB500);
        issue(2'd1, 1, 16'h0000);        // ignored while busy
        chk("R12 oe settle", bus_ad_oe, 1);
        wait_idle();
        chk("R4 rdata", host_rdata, 16'hBEEF);
        chk("R4 rvalid", host_rvalid, 1);
        issue(2'd2, 0, '0);
        chk("R6 ctrl kept", bus_ad, 16'hB500);
        wait_idle();

        // write transfer
        issue(2'd1, 1, 16'hB480);
        issue(2'd2, 1, 16'h1234);
        host_wdata = 16'hFFFF;
        cyc();
        chk("R5 data", bus_ad, 16'h1234);
        chk("R5 dat_stb", bus_dat_stb, 1);
        cyc();
        chk("R5 done", host_busy, 0);

        // interrupts
        issue(2'd3, 1, 16'h0003);
        bus_req_n = 2'b00;
        #0;
        chk("R10 irq", host_irq, 1);
        chk("R10 prio", host_irq_chan, 0);
        host_irq_ack = 1; cyc(); host_irq_ack = 0;
        chk("R11 chan1 next", host_irq_chan, 1);
        host_irq_ack = 1; cyc(); host_irq_ack = 0;
        chk("R11 all cleared", host_irq, 0);
        issue(2'd3, 1, 16'h0002);
        chk("R9 en1 only", host_irq_chan, 1);
        host_irq_ack = 1;
        issue(2'd3, 1, 16'h0003);
        host_irq_ack = 0;
        chk("R11 write wins", host_irq_chan, 0);
        issue(2'd1, 0, '0);
        chk("R9 status", host_rdata, 16'h0030);
        bus_req_n = 2'b11;

        // parity flags and bus reset
        bus_perr_local = 1; cyc(); bus_perr_local = 0;
        issue(2'd1, 0, '0);
        chk("R8 local set", host_rdata, 16'h0037);
        repeat (4) cyc();
        issue(2'd1, 0, '0);
        chk("R8 sticky", host_rdata, 16'h0037);
        bus_perr_remote = 1;
        issue(2'd0, 1, '0);
        bus_perr_remote = 0;
        wait_idle();
        issue(2'd1, 0, '0);
        chk("R8 set wins", host_rdata, 16'h003B);
        issue(2'd0, 1, '0);
        n = 0;
        while (bus_rst && n < 100) begin n++; cyc(); end
        chk("R7 length", n, RSTC);
        issue(2'd1, 0, '0);
        chk("R7 cleared", host_rdata, 16'h0033);

        // randomized traffic, compared every cycle by the model
        lcg = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            host_req        = lcg[31:30] != 2'b00;
            host_fn         = (lcg[29:27] == 3'd0) ? 2'd0 : lcg[26:25];
            host_wr         = lcg[24];
            host_wdata      = {lcg[23:20], lcg[17:6]};
            bus_din         = lcg[15:0] ^ 16'h5A5A;
            bus_req_n       = lcg[5:4];
            host_irq_ack    = lcg[3];
            bus_perr_local  = lcg[2:0] == 3'd7;
            bus_perr_remote = lcg[2:0] == 3'd6;
            cyc();
        end
        host_req = 0; host_irq_ack = 0; bus_perr_local = 0; bus_perr_remote = 0;
        wait_idle();
        cyc();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog act=running exp=finished");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule